// File: doc/BRIEF.md
# GPIO Edge Detect Interrupt Unit

This block watches up to 121 general-purpose input pins and turns chosen transitions into interrupt requests. Each pin has two enable bits, one for rising transitions and one for falling transitions. When a transition that is enabled arrives, the block sets a sticky status bit for that pin. Software clears a status bit by writing 1 to it.

Pins 0 and 1 each drive their own interrupt line. Every other pin feeds one shared request, which is high while any of their status bits is set. Each pin passes through a two-flop synchronizer, and an edge is found by comparing the synchronized level with its value one cycle earlier.

The rising-enable, falling-enable and status registers are each 128 bits wide, split into four 32-bit banks on a plain word bus. Writes take effect on the clock edge. Reads are combinational from the address. The block has no state machine: the datapath is the same every cycle, with a synchronizer stage, a compare stage and a status update.

Top module: `gpio_edge_irq`

## Requirements
- R1: A 0-to-1 transition on pin k sets status bit k when rising enable bit k is 1. It does not set the bit when only the falling enable bit is 1.
- R2: A 1-to-0 transition on pin k sets status bit k when falling enable bit k is 1. It does not set the bit when only the rising enable bit is 1.
- R3: With both enable bits of a pin set, either transition sets its status bit. With neither set, no transition sets it.
- R4: A status bit stays set after the pin returns to its old level. Writing 1 to the bit clears it. Writing 0 to the bit leaves it unchanged.
- R5: irq_pin0 is high exactly while status bit 0 is set. irq_pin1 is high exactly while status bit 1 is set.
- R6: irq_shared is high while any status bit from 2 to 120 is set. It stays high until every one of those bits has been cleared.
- R7: Byte addresses of the registers (bank b = pins 32b..32b+31, bit n of a bank = pin 32b+n):
  - rising enable: 0x30, 0x34 and 0x38 for banks 0 to 2, and 0x130 for bank 3.
  - falling enable: 0x3C, 0x40 and 0x44 for banks 0 to 2, and 0x13C for bank 3.
  - status: 0x48, 0x4C and 0x50 for banks 0 to 2, and 0x148 for bank 3.
- R8: Bits 25 to 31 of bank 3 have no pin. Writes to those bits are ignored, and they always read as 0.
- R9: After reset all enable and status bits are 0 and all three interrupt outputs are low.
- R10: If a new enabled edge and a write-1 clear hit the same status bit in the same cycle, the bit stays set.
- R11: After a pin changes between clock edges, its status bit is set on the third rising clock edge that follows the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_i | input | 121 | Raw pin levels |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 9 | Byte address of the register word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| irq_pin0 | output | 1 | Interrupt for pin 0 |
| irq_pin1 | output | 1 | Interrupt for pin 1 |
| irq_shared | output | 1 | Shared interrupt for pins 2 to 120 |

## Verification
The bench drives a single edge at the exact cycle in which a clear of the same bit is written. A design that let the clear win would lose that event and report the status bit as 0.

The bench also counts clock edges after a pin change, which exposes a synchronizer that is one stage too short or too long. It writes 0 to a set status bit, and a design that stored the written value instead of clearing on 1 would drop the bit. It writes all ones to the last bank, where any reserved bit left writable would read back as 1.

Two shared pins are set and then cleared one at a time. An OR taken over the wrong range of pins, or a line that follows only one pin, would let irq_shared fall too early.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;

    localparam int unsigned WORD_W = 32;
    localparam int unsigned ADDR_W = 9;
    localparam int unsigned NBANK  = 4;
    localparam int unsigned TOTAL  = NBANK * WORD_W;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_RISE,
        SEL_FALL,
        SEL_STAT
    } reg_sel_e;

    typedef struct packed {
        reg_sel_e   sel;
        logic [1:0] bank;
    } reg_hit_t;

    // Word map: three words per register in the low page, one in the high page.
    function automatic reg_hit_t decode_addr(input logic [ADDR_W-1:0] a);
        reg_hit_t   h;
        logic [7:0] lo;
        logic [7:0] d;
        h.sel  = SEL_NONE;
        h.bank = 2'd0;
        lo     = a[7:0];
        d      = 8'h00;
        if (a[1:0] == 2'b00) begin
            if (!a[8]) begin
                if (lo >= 8'h30 && lo < 8'h3C) begin
                    h.sel = SEL_RISE;
                    d     = lo - 8'h30;
                end else if (lo >= 8'h3C && lo < 8'h48) begin
                    h.sel = SEL_FALL;
                    d     = lo - 8'h3C;
                end else if (lo >= 8'h48 && lo < 8'h54) begin
                    h.sel = SEL_STAT;
                    d     = lo - 8'h48;
                end
                h.bank = d[3:2];
            end else begin
                h.bank = 2'd3;
                unique case (lo)
                    8'h30:   h.sel = SEL_RISE;
                    8'h3C:   h.sel = SEL_FALL;
                    8'h48:   h.sel = SEL_STAT;
                    default: h.sel = SEL_NONE;
                endcase
            end
        end
        return h;
    endfunction

endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
    parameter int unsigned NPINS = 121
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] pin_i,
    output logic [NPINS-1:0] lvl_o,
    output logic [NPINS-1:0] rise_o,
    output logic [NPINS-1:0] fall_o
);

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        logic meta_q;
        logic lvl_q;
        logic prev_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta_q <= 1'b0;
                lvl_q  <= 1'b0;
                prev_q <= 1'b0;
            end else begin
                meta_q <= pin_i[i];
                lvl_q  <= meta_q;
                prev_q <= lvl_q;
            end
        end

        assign lvl_o[i]  = lvl_q;
        assign rise_o[i] = lvl_q & ~prev_q;
        assign fall_o[i] = ~lvl_q & prev_q;
    end

endmodule

// File: rtl/gpio_edge_regs.sv
module gpio_edge_regs
    import gpio_edge_pkg::*;
#(
    parameter int unsigned NPINS = 121
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    input  logic [NPINS-1:0]  rise_p,
    input  logic [NPINS-1:0]  fall_p,
    output logic [NPINS-1:0]  rise_en,
    output logic [NPINS-1:0]  fall_en,
    output logic [NPINS-1:0]  status,
    output logic [NPINS-1:0]  edge_hit
);

    localparam logic [TOTAL-1:0] VALID =
        (NPINS >= TOTAL) ? {TOTAL{1'b1}} : ((TOTAL'(1) << NPINS) - TOTAL'(1));

    reg_hit_t         hit;
    logic [TOTAL-1:0] lane;
    logic [TOTAL-1:0] wide_wdata;
    logic [TOTAL-1:0] rise_q;
    logic [TOTAL-1:0] fall_q;
    logic [TOTAL-1:0] stat_q;
    logic [TOTAL-1:0] hit_wide;
    logic [TOTAL-1:0] clr_wide;
    logic             rise_wr;
    logic             fall_wr;
    logic             stat_wr;

    assign hit        = decode_addr(reg_addr);
    assign wide_wdata = {NBANK{reg_wdata}};
    assign rise_wr    = reg_we && (hit.sel == SEL_RISE);
    assign fall_wr    = reg_we && (hit.sel == SEL_FALL);
    assign stat_wr    = reg_we && (hit.sel == SEL_STAT);

    for (genvar b = 0; b < NBANK; b++) begin : g_lane
        assign lane[b*WORD_W +: WORD_W] = {WORD_W{hit.bank == 2'(b)}};
    end

    assign hit_wide = ((TOTAL'(rise_p) & rise_q) | (TOTAL'(fall_p) & fall_q)) & VALID;
    assign clr_wide = stat_wr ? (wide_wdata & lane) : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rise_q <= '0;
            fall_q <= '0;
            stat_q <= '0;
        end else begin
            if (rise_wr) begin
                rise_q <= ((rise_q & ~lane) | (wide_wdata & lane)) & VALID;
            end
            if (fall_wr) begin
                fall_q <= ((fall_q & ~lane) | (wide_wdata & lane)) & VALID;
            end
            stat_q <= ((stat_q & ~clr_wide) | hit_wide) & VALID;
        end
    end

    always_comb begin
        unique case (hit.sel)
            SEL_RISE: reg_rdata = rise_q[{hit.bank, 5'd0} +: WORD_W];
            SEL_FALL: reg_rdata = fall_q[{hit.bank, 5'd0} +: WORD_W];
            SEL_STAT: reg_rdata = stat_q[{hit.bank, 5'd0} +: WORD_W];
            default:  reg_rdata = '0;
        endcase
    end

    assign rise_en  = rise_q[NPINS-1:0];
    assign fall_en  = fall_q[NPINS-1:0];
    assign status   = stat_q[NPINS-1:0];
    assign edge_hit = hit_wide[NPINS-1:0];

endmodule

// File: rtl/gpio_edge_irq.sv
module gpio_edge_irq
    import gpio_edge_pkg::*;
#(
    parameter int unsigned NPINS = 121
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NPINS-1:0]  pin_i,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    output logic              irq_pin0,
    output logic              irq_pin1,
    output logic              irq_shared
);

    logic [NPINS-1:0] pin_lvl;
    logic [NPINS-1:0] rise_p;
    logic [NPINS-1:0] fall_p;
    logic [NPINS-1:0] rise_en;
    logic [NPINS-1:0] fall_en;
    logic [NPINS-1:0] status;
    logic [NPINS-1:0] edge_hit;

    gpio_pin_sync #(.NPINS(NPINS)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (pin_i),
        .lvl_o  (pin_lvl),
        .rise_o (rise_p),
        .fall_o (fall_p)
    );

    gpio_edge_regs #(.NPINS(NPINS)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .rise_p    (rise_p),
        .fall_p    (fall_p),
        .rise_en   (rise_en),
        .fall_en   (fall_en),
        .status    (status),
        .edge_hit  (edge_hit)
    );

    assign irq_pin0   = status[0];
    assign irq_pin1   = status[1];
    assign irq_shared = |status[NPINS-1:2];

endmodule

// File: rtl/gpio_edge_irq_chk.sv
module gpio_edge_irq_chk
    import gpio_edge_pkg::*;
#(
    parameter int unsigned NPINS = 121
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_we,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [WORD_W-1:0] reg_rdata,
    input logic [NPINS-1:0]  lvl,
    input logic [NPINS-1:0]  rise_en,
    input logic [NPINS-1:0]  fall_en,
    input logic [NPINS-1:0]  status,
    input logic [NPINS-1:0]  edge_hit,
    input logic              irq_shared
);

    localparam int unsigned LAST_USED = NPINS - (NBANK - 1) * WORD_W;

    for (genvar k = 0; k < NPINS; k++) begin : g_bit
        p_rise_sets_r1: assert property (@(posedge clk) disable iff (!rst_n)
            ($rose(lvl[k]) && rise_en[k]) |=> status[k]);

        p_fall_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
            ($fell(lvl[k]) && fall_en[k]) |=> status[k]);

        p_no_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (!status[k] && !edge_hit[k]) |=> !status[k]);

        p_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (status[k] && !reg_we) |=> status[k]);
    end

    p_shared_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_shared && !reg_we) |=> irq_shared);

    if (LAST_USED < WORD_W) begin : g_rsv
        p_reserved_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
            reg_addr[8] |-> (reg_rdata[WORD_W-1:LAST_USED] == '0));
    end

endmodule

bind gpio_edge_irq gpio_edge_irq_chk #(.NPINS(NPINS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_we     (reg_we),
    .reg_addr   (reg_addr),
    .reg_rdata  (reg_rdata),
    .lvl        (pin_lvl),
    .rise_en    (rise_en),
    .fall_en    (fall_en),
    .status     (status),
    .edge_hit   (edge_hit),
    .irq_shared (irq_shared)
);

// File: tb/sim_gpio_edge_irq.sv
module sim_gpio_edge_irq;

    localparam int NP = 121;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NP-1:0] pin_i = '0;
    logic          reg_we = 1'b0;
    logic [8:0]    reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic          irq_pin0;
    logic          irq_pin1;
    logic          irq_shared;

    int n_run  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    gpio_edge_irq #(.NPINS(NP)) u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .pin_i      (pin_i),
        .reg_we     (reg_we),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .irq_pin0   (irq_pin0),
        .irq_pin1   (irq_pin1),
        .irq_shared (irq_shared)
    );

    // kind: 0 rising enable, 1 falling enable, 2 status (map of R7)
    function automatic logic [8:0] addr_of(input int kind, input int bank);
        int base;
        base = (kind == 0) ? 'h30 : (kind == 1) ? 'h3C : 'h48;
        return (bank < 3) ? 9'(base + 4 * bank) : 9'(base + 'h100);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [8:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [8:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clear_all();
        for (int b = 0; b < 4; b++) begin
            wr(addr_of(0, b), 32'h0);
            wr(addr_of(1, b), 32'h0);
            wr(addr_of(2, b), 32'hFFFF_FFFF);
        end
    endtask

    // entry: [10:4] pin, [3] rise en, [2] fall en, [1] 1=rising edge, [0] expect set
    localparam logic [10:0] VEC [12] = '{
        {7'd0,   1'b1, 1'b0, 1'b1, 1'b1},
        {7'd0,   1'b0, 1'b1, 1'b1, 1'b0},
        {7'd1,   1'b0, 1'b1, 1'b0, 1'b1},
        {7'd1,   1'b1, 1'b0, 1'b0, 1'b0},
        {7'd5,   1'b1, 1'b1, 1'b1, 1'b1},
        {7'd5,   1'b1, 1'b1, 1'b0, 1'b1},
        {7'd40,  1'b0, 1'b0, 1'b1, 1'b0},
        {7'd70,  1'b0, 1'b1, 1'b0, 1'b1},
        {7'd96,  1'b1, 1'b0, 1'b1, 1'b1},
        {7'd120, 1'b1, 1'b1, 1'b0, 1'b1},
        {7'd31,  1'b1, 1'b0, 1'b1, 1'b1},
        {7'd32,  1'b0, 1'b1, 1'b1, 1'b0}
    };

    initial begin : watchdog
        #(4 * 150000);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin : main
        logic [31:0] d;
        int p, b, bit_i;
        idle(3);
        rst_n = 1'b1;
        idle(2);

        // R9: reset state
        for (int k = 0; k < 3; k++) begin
            for (int bb = 0; bb < 4; bb++) begin
                rd(addr_of(k, bb), d);
                chk("R9 register zero after reset", d, 32'h0);
            end
        end
        chk("R9 irq lines low", {29'h0, irq_pin0, irq_pin1, irq_shared}, 32'h0);

        // R1 R2 R3 R5 R6 R7: vector walk
        foreach (VEC[i]) begin
            p = int'(VEC[i][10:4]);
            b = p / 32;
            bit_i = p % 32;
            clear_all();
            @(negedge clk);
            pin_i = '0;
            pin_i[p] = ~VEC[i][1];
            idle(5);
            wr(addr_of(2, b), 32'hFFFF_FFFF);
            wr(addr_of(0, b), 32'(VEC[i][3]) << bit_i);
            wr(addr_of(1, b), 32'(VEC[i][2]) << bit_i);
            @(negedge clk);
            pin_i[p] = VEC[i][1];
            idle(5);
            rd(addr_of(2, b), d);
            chk("R1 R2 R3 R7 status after edge", d, 32'(VEC[i][0]) << bit_i);
            chk("R5 R6 irq lines",
                {29'h0, irq_pin0, irq_pin1, irq_shared},
                {29'h0, VEC[i][0] && p == 0, VEC[i][0] && p == 1, VEC[i][0] && p > 1});
        end

        // R8: reserved bits of last bank
        clear_all();
        wr(addr_of(0, 3), 32'hFFFF_FFFF);
        rd(addr_of(0, 3), d);
        chk("R8 reserved bits read zero", d, 32'h01FF_FFFF);
        wr(addr_of(0, 3), 32'h0);

        // R11: latency, and R4: sticky, write 0, write 1
        clear_all();
        @(negedge clk); pin_i = '0;
        idle(5);
        wr(addr_of(0, 0), 32'h1);
        @(negedge clk);
        pin_i[0] = 1'b1;
        @(posedge clk); @(posedge clk);
        #1 chk("R11 not set after two edges", {31'h0, irq_pin0}, 32'h0);
        @(posedge clk);
        #1 chk("R11 set on third edge", {31'h0, irq_pin0}, 32'h1);
        @(negedge clk); pin_i[0] = 1'b0;
        idle(5);
        rd(addr_of(2, 0), d);
        chk("R4 sticky after pin returns", d, 32'h1);
        wr(addr_of(2, 0), 32'h0);
        rd(addr_of(2, 0), d);
        chk("R4 write 0 no effect", d, 32'h1);
        wr(addr_of(2, 0), 32'h1);
        rd(addr_of(2, 0), d);
        chk("R4 write 1 clears", d, 32'h0);
        chk("R5 irq_pin0 low after clear", {31'h0, irq_pin0}, 32'h0);

        // R10: edge and clear in the same cycle
        clear_all();
        wr(addr_of(0, 0), 32'h8);
        wr(addr_of(1, 0), 32'h8);
        @(negedge clk); pin_i[3] = 1'b1;
        idle(5);
        @(negedge clk); pin_i[3] = 1'b0;
        @(posedge clk);
        @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = addr_of(2, 0); reg_wdata = 32'h8;
        @(negedge clk);
        reg_we = 1'b0;
        rd(addr_of(2, 0), d);
        chk("R10 new edge beats clear", d, 32'h8);

        // R6: shared line holds until all sources are clear
        clear_all();
        wr(addr_of(0, 0), 32'h4);
        wr(addr_of(0, 2), 32'h1);
        @(negedge clk); pin_i = '0; pin_i[2] = 1'b1; pin_i[64] = 1'b1;
        idle(5);
        chk("R6 shared high for two pins", {31'h0, irq_shared}, 32'h1);
        wr(addr_of(2, 0), 32'h4);
        #1 chk("R6 shared high with one left", {31'h0, irq_shared}, 32'h1);
        wr(addr_of(2, 2), 32'h1);
        #1 chk("R6 shared low when all clear", {31'h0, irq_shared}, 32'h0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule